// File: doc/BRIEF.md
# Trap and Interrupt Entry Controller

This block sits beside the execute stage of a small soft-core processor and decides, every cycle, whether the core must leave its normal instruction flow. Four things can cause that: an address-translation fault, a hardware exception, a hardware break, or a pending external interrupt. When one of them is accepted, the block computes in a single step everything the core needs in order to enter the handler. That is the handler address, taken from a configurable vector base. It is also the link register index and value, the rewritten machine status word, and the exception status and address words. Last, it gives the saved branch target for a fault that lands in a delay slot.

All results are registered. The core presents its current program counter, status word, instruction-sequence flags and request lines. One clock edge later the controller drives a one-cycle `taken` pulse together with the write enables and values. The same pulse also tells the core to drop its load reservation and clear its instruction-sequence flags. The return address for a translation fault is chosen so that an interrupted branch or immediate-prefix sequence restarts from its first instruction.

Top module: `exc_entry_ctrl`

## Requirements
- R1: An interrupt is accepted only when `irq_pend` is high, status bit 1 (interrupt enable) is 1, status bit 9 (exception active) and status bit 3 (break active) are both 0, and neither `flag_dslot` nor `flag_imm` is set. Otherwise the interrupt produces no entry.
- R2: An accepted interrupt reports cause 4, writes the current PC to register 14, jumps to vector base + 0x10, clears status bit 1 and does not write the status word.
- R3: A break reports cause 3, sets status bit 3, writes the current PC to register 16 and jumps to vector base + 0x18.
- R4: A hardware exception reports cause 2, sets status bit 9, writes PC + 4 to register 17 and jumps to vector base + 0x20. When not unaligned, the status word code field [4:0] equals `exc_code`.
- R5: A translation fault (cause 1) sets status bit 9, jumps to vector base + 0x20 and writes register 17. The value is PC − 8 in a delay slot with `flag_bimm` set, PC − 4 in a delay slot without it, PC − 4 after an immediate prefix, and PC otherwise.
- R6: For causes 1 and 2, status word bit 12 equals `flag_dslot`. When that bit is 1, `br_target` is written to the branch target output; otherwise no branch target write occurs.
- R7: A translation fault writes a status word code of 17 (protection, fetch), 16 (protection, data), 19 (miss, fetch) or 18 (miss, data). Bit 10 is set exactly when `flt_acc` is 2 (store); fetch is 0 and load is 1. The faulting address is written to the address output.
- R8: On every entry, status bits 11 (user mode) and 13 (virtual mode) are copied into bits 12 and 14 respectively, and bits 11 and 13 are then cleared.
- R9: `taken`, `resv_kill` and `iflag_clr` pulse for exactly the cycle after each accepted request. Without an accepted request, no write enable is raised. After reset all outputs are 0.
- R10: An unaligned hardware exception writes code 1 into bits [4:0] and places `exc_syndrome` in bits [11:5] of the status word. It also writes `exc_addr` to the address output.
- R11: When requests coincide, a translation fault wins over a hardware exception, which wins over a break, which wins over an interrupt.
- R12: A hardware exception request has no effect while `cfg_exc_en` is low. A lower-priority request present in the same cycle is taken instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_exc_en | input | 1 | Hardware exceptions are configured in |
| cfg_vec_base | input | XLEN | Handler vector base address |
| cur_pc | input | XLEN | PC of the current instruction |
| cur_msr | input | MSR_W | Current machine status word |
| flag_dslot | input | 1 | Current instruction sits in a delay slot |
| flag_imm | input | 1 | Current instruction follows an immediate prefix |
| flag_bimm | input | 1 | Delay-slot branch was itself prefixed |
| br_target | input | XLEN | Target of the pending branch |
| irq_pend | input | 1 | External interrupt pending |
| brk_req | input | 1 | Hardware break request |
| exc_req | input | 1 | Hardware exception request |
| exc_unaligned | input | 1 | The exception is an unaligned data access |
| exc_code | input | 5 | Exception code for other exceptions |
| exc_syndrome | input | SYN_W | Syndrome bits from the instruction |
| exc_addr | input | XLEN | Address of the unaligned access |
| flt_req | input | 1 | Translation fault request |
| flt_prot | input | 1 | 1 = protection fault, 0 = miss |
| flt_acc | input | 2 | Access type: 0 fetch, 1 load, 2 store |
| flt_addr | input | XLEN | Faulting address |
| taken | output | 1 | Entry pulse |
| cause | output | 3 | 1 fault, 2 exception, 3 break, 4 interrupt |
| new_pc | output | XLEN | Handler address |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_val | output | XLEN | Link register value |
| msr_out | output | MSR_W | New machine status word |
| esr_we | output | 1 | Status word write enable |
| esr_val | output | ESR_W | Status word value |
| ear_we | output | 1 | Address output write enable |
| ear_val | output | XLEN | Faulting address value |
| btr_we | output | 1 | Branch target write enable |
| btr_val | output | XLEN | Saved branch target |
| resv_kill | output | 1 | Cancel the load reservation |
| iflag_clr | output | 1 | Clear instruction-sequence flags |

## Verification
Every result of this block becomes visible exactly one rising edge after the edge that samples the request. This covers the entry pulse, handler address, link write, status words and branch target. Nothing is due later, and nothing is held beyond that cycle unless the request is repeated. The bench changes inputs on the falling edge and reads every output shortly after the following rising edge, so each check sees the registered answer to precisely one input set. The pulse test also reads the cycle after that to confirm that `taken` and the clear strobes have already dropped.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [2:0] {
    CS_NONE  = 3'd0,
    CS_XLAT  = 3'd1,
    CS_HWEXC = 3'd2,
    CS_BREAK = 3'd3,
    CS_IRQ   = 3'd4
  } cause_e;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  // status word bit positions; each saved copy sits one bit above its live bit
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_VM  = 13;

  // exception status word layout
  localparam int CODE_W      = 5;
  localparam int ESR_ST      = 10;
  localparam int ESR_DS      = 12;
  localparam int ESR_SYN_LSB = 5;
  localparam int LR_W        = 5;

  localparam logic [CODE_W-1:0] CODE_UNALIGNED  = 5'd1;
  localparam logic [CODE_W-1:0] CODE_PROT_DATA  = 5'd16;
  localparam logic [CODE_W-1:0] CODE_PROT_FETCH = 5'd17;
  localparam logic [CODE_W-1:0] CODE_MISS_DATA  = 5'd18;
  localparam logic [CODE_W-1:0] CODE_MISS_FETCH = 5'd19;

  localparam logic [LR_W-1:0] LR_IRQ = 5'd14;
  localparam logic [LR_W-1:0] LR_BRK = 5'd16;
  localparam logic [LR_W-1:0] LR_EXC = 5'd17;

  localparam logic [7:0] VOFS_IRQ = 8'h10;
  localparam logic [7:0] VOFS_BRK = 8'h18;
  localparam logic [7:0] VOFS_EXC = 8'h20;

endpackage

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_entry_pkg::*;
#(
  parameter int MSR_W = 32
) (
  input  logic             irq_pend,
  input  logic             brk_req,
  input  logic             exc_req,
  input  logic             exc_en,
  input  logic             flt_req,
  input  logic [MSR_W-1:0] msr,
  input  logic             dslot,
  input  logic             imm,
  output cause_e           cause
);

  logic irq_ok;

  always_comb begin
    irq_ok = irq_pend && msr[MSR_IE] && !msr[MSR_EIP] && !msr[MSR_BIP]
             && !dslot && !imm;
    if (flt_req)                cause = CS_XLAT;
    else if (exc_req && exc_en) cause = CS_HWEXC;
    else if (brk_req)           cause = CS_BREAK;
    else if (irq_ok)            cause = CS_IRQ;
    else                        cause = CS_NONE;
  end

endmodule

// File: rtl/exc_link_calc.sv
module exc_link_calc
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cause_e          cause,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] vec_base,
  input  logic            dslot,
  input  logic            imm,
  input  logic            bimm,
  output logic [XLEN-1:0] new_pc,
  output logic            link_we,
  output logic [LR_W-1:0] link_idx,
  output logic [XLEN-1:0] link_val
);

  logic [XLEN-1:0] xlat_ret;

  always_comb begin
    if (dslot)    xlat_ret = pc - (bimm ? XLEN'(8) : XLEN'(4));
    else if (imm) xlat_ret = pc - XLEN'(4);
    else          xlat_ret = pc;
  end

  always_comb begin
    new_pc   = '0;
    link_we  = 1'b0;
    link_idx = '0;
    link_val = '0;
    unique case (cause)
      CS_IRQ: begin
        new_pc   = vec_base + XLEN'(VOFS_IRQ);
        link_we  = 1'b1;
        link_idx = LR_IRQ;
        link_val = pc;
      end
      CS_BREAK: begin
        new_pc   = vec_base + XLEN'(VOFS_BRK);
        link_we  = 1'b1;
        link_idx = LR_BRK;
        link_val = pc;
      end
      CS_HWEXC: begin
        new_pc   = vec_base + XLEN'(VOFS_EXC);
        link_we  = 1'b1;
        link_idx = LR_EXC;
        link_val = pc + XLEN'(4);
      end
      CS_XLAT: begin
        new_pc   = vec_base + XLEN'(VOFS_EXC);
        link_we  = 1'b1;
        link_idx = LR_EXC;
        link_val = xlat_ret;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int MSR_W = 32,
  parameter int ESR_W = 32,
  parameter int SYN_W = 7
) (
  input  cause_e            cause,
  input  logic [MSR_W-1:0]  msr_in,
  input  logic              dslot,
  input  logic [XLEN-1:0]   br_target,
  input  logic              flt_prot,
  input  logic [1:0]        flt_acc,
  input  logic [XLEN-1:0]   flt_addr,
  input  logic              exc_unaligned,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [SYN_W-1:0]  exc_syn,
  input  logic [XLEN-1:0]   exc_addr,
  output logic [MSR_W-1:0]  msr_new,
  output logic              esr_we,
  output logic [ESR_W-1:0]  esr_val,
  output logic              ear_we,
  output logic [XLEN-1:0]   ear_val,
  output logic              btr_we,
  output logic [XLEN-1:0]   btr_val
);

  logic [MSR_W-1:0]  m;
  logic [CODE_W-1:0] xlat_code;
  logic              is_fetch;
  logic              fault_like;

  assign is_fetch   = (flt_acc == ACC_FETCH);
  assign fault_like = (cause == CS_XLAT) || (cause == CS_HWEXC);

  always_comb begin
    if (flt_prot) xlat_code = is_fetch ? CODE_PROT_FETCH : CODE_PROT_DATA;
    else          xlat_code = is_fetch ? CODE_MISS_FETCH : CODE_MISS_DATA;
  end

  // status word: cause-specific bit first, then mode save and clear
  always_comb begin
    m = msr_in;
    unique case (cause)
      CS_IRQ:            m[MSR_IE]  = 1'b0;
      CS_BREAK:          m[MSR_BIP] = 1'b1;
      CS_HWEXC, CS_XLAT: m[MSR_EIP] = 1'b1;
      default: ;
    endcase
    m[MSR_UM+1] = m[MSR_UM];
    m[MSR_VM+1] = m[MSR_VM];
    m[MSR_UM]   = 1'b0;
    m[MSR_VM]   = 1'b0;
    msr_new     = m;
  end

  always_comb begin
    esr_val = '0;
    if (cause == CS_XLAT) begin
      esr_val[CODE_W-1:0] = xlat_code;
      esr_val[ESR_ST]     = (flt_acc == ACC_STORE);
    end else if (exc_unaligned) begin
      esr_val[CODE_W-1:0]              = CODE_UNALIGNED;
      esr_val[ESR_SYN_LSB +: SYN_W]    = exc_syn;
    end else begin
      esr_val[CODE_W-1:0] = exc_code;
    end
    esr_val[ESR_DS] = dslot;
  end

  always_comb begin
    esr_we  = fault_like;
    ear_we  = (cause == CS_XLAT) || ((cause == CS_HWEXC) && exc_unaligned);
    ear_val = (cause == CS_XLAT) ? flt_addr : exc_addr;
    btr_we  = fault_like && dslot;
    btr_val = br_target;
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int MSR_W = 32,
  parameter int ESR_W = 32,
  parameter int SYN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_exc_en,
  input  logic [XLEN-1:0]  cfg_vec_base,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [MSR_W-1:0] cur_msr,
  input  logic             flag_dslot,
  input  logic             flag_imm,
  input  logic             flag_bimm,
  input  logic [XLEN-1:0]  br_target,
  input  logic             irq_pend,
  input  logic             brk_req,
  input  logic             exc_req,
  input  logic             exc_unaligned,
  input  logic [4:0]       exc_code,
  input  logic [SYN_W-1:0] exc_syndrome,
  input  logic [XLEN-1:0]  exc_addr,
  input  logic             flt_req,
  input  logic             flt_prot,
  input  logic [1:0]       flt_acc,
  input  logic [XLEN-1:0]  flt_addr,
  output logic             taken,
  output logic [2:0]       cause,
  output logic [XLEN-1:0]  new_pc,
  output logic             link_we,
  output logic [4:0]       link_idx,
  output logic [XLEN-1:0]  link_val,
  output logic [MSR_W-1:0] msr_out,
  output logic             esr_we,
  output logic [ESR_W-1:0] esr_val,
  output logic             ear_we,
  output logic [XLEN-1:0]  ear_val,
  output logic             btr_we,
  output logic [XLEN-1:0]  btr_val,
  output logic             resv_kill,
  output logic             iflag_clr
);

  cause_e           sel;
  logic [XLEN-1:0]  n_pc, n_link, n_ear, n_btr;
  logic             n_link_we, n_esr_we, n_ear_we, n_btr_we;
  logic [LR_W-1:0]  n_idx;
  logic [MSR_W-1:0] n_msr;
  logic [ESR_W-1:0] n_esr;

  exc_cause_sel #(.MSR_W(MSR_W)) u_sel (
    .irq_pend (irq_pend),
    .brk_req  (brk_req),
    .exc_req  (exc_req),
    .exc_en   (cfg_exc_en),
    .flt_req  (flt_req),
    .msr      (cur_msr),
    .dslot    (flag_dslot),
    .imm      (flag_imm),
    .cause    (sel)
  );

  exc_link_calc #(.XLEN(XLEN)) u_link (
    .cause    (sel),
    .pc       (cur_pc),
    .vec_base (cfg_vec_base),
    .dslot    (flag_dslot),
    .imm      (flag_imm),
    .bimm     (flag_bimm),
    .new_pc   (n_pc),
    .link_we  (n_link_we),
    .link_idx (n_idx),
    .link_val (n_link)
  );

  exc_state_calc #(.XLEN(XLEN), .MSR_W(MSR_W), .ESR_W(ESR_W), .SYN_W(SYN_W)) u_state (
    .cause         (sel),
    .msr_in        (cur_msr),
    .dslot         (flag_dslot),
    .br_target     (br_target),
    .flt_prot      (flt_prot),
    .flt_acc       (flt_acc),
    .flt_addr      (flt_addr),
    .exc_unaligned (exc_unaligned),
    .exc_code      (exc_code),
    .exc_syn       (exc_syndrome),
    .exc_addr      (exc_addr),
    .msr_new       (n_msr),
    .esr_we        (n_esr_we),
    .esr_val       (n_esr),
    .ear_we        (n_ear_we),
    .ear_val       (n_ear),
    .btr_we        (n_btr_we),
    .btr_val       (n_btr)
  );

  logic taken_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q  <= 1'b0;
      cause    <= '0;
      new_pc   <= '0;
      link_we  <= 1'b0;
      link_idx <= '0;
      link_val <= '0;
      msr_out  <= '0;
      esr_we   <= 1'b0;
      esr_val  <= '0;
      ear_we   <= 1'b0;
      ear_val  <= '0;
      btr_we   <= 1'b0;
      btr_val  <= '0;
    end else begin
      taken_q  <= (sel != CS_NONE);
      cause    <= sel;
      new_pc   <= n_pc;
      link_we  <= n_link_we;
      link_idx <= n_idx;
      link_val <= n_link;
      msr_out  <= n_msr;
      esr_we   <= n_esr_we;
      esr_val  <= n_esr;
      ear_we   <= n_ear_we;
      ear_val  <= n_ear;
      btr_we   <= n_btr_we;
      btr_val  <= n_btr;
    end
  end

  assign taken     = taken_q;
  assign resv_kill = taken_q;
  assign iflag_clr = taken_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int MSR_W = 32,
  parameter int ESR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_exc_en,
  input logic [XLEN-1:0]  cfg_vec_base,
  input logic [XLEN-1:0]  cur_pc,
  input logic [MSR_W-1:0] cur_msr,
  input logic             flag_dslot,
  input logic             flag_imm,
  input logic             flag_bimm,
  input logic             irq_pend,
  input logic             flt_req,
  input logic [1:0]       flt_acc,
  input logic [XLEN-1:0]  flt_addr,
  input logic             taken,
  input logic [2:0]       cause,
  input logic [XLEN-1:0]  new_pc,
  input logic             link_we,
  input logic [4:0]       link_idx,
  input logic [XLEN-1:0]  link_val,
  input logic [MSR_W-1:0] msr_out,
  input logic             esr_we,
  input logic [ESR_W-1:0] esr_val,
  input logic             ear_we,
  input logic [XLEN-1:0]  ear_val,
  input logic             btr_we,
  input logic             resv_kill,
  input logic             iflag_clr
);

  assert_irq_gate_R1: assert property (@(posedge clk) disable iff (rst)
    (taken && cause == 3'd4) |-> $past(irq_pend && cur_msr[MSR_IE] && !cur_msr[MSR_EIP]
                                       && !cur_msr[MSR_BIP] && !flag_dslot && !flag_imm));

  assert_irq_entry_R2: assert property (@(posedge clk) disable iff (rst)
    (taken && cause == 3'd4) |-> (link_idx == 5'd14 && !msr_out[MSR_IE] && !esr_we
                                  && new_pc == $past(cfg_vec_base) + XLEN'(16)));

  assert_break_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (taken && cause == 3'd3) |-> (msr_out[MSR_BIP] && link_idx == 5'd16
                                  && link_val == $past(cur_pc)));

  assert_hwexc_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (taken && cause == 3'd2) |-> (msr_out[MSR_EIP] && link_idx == 5'd17
                                  && link_val == $past(cur_pc) + XLEN'(4)));

  assert_fault_ret_R5: assert property (@(posedge clk) disable iff (rst)
    (taken && cause == 3'd1 && $past(flag_dslot && flag_bimm))
      |-> (link_val == $past(cur_pc) - XLEN'(8)));

  assert_dslot_save_R6: assert property (@(posedge clk) disable iff (rst)
    (taken && (cause == 3'd1 || cause == 3'd2))
      |-> (esr_val[ESR_DS] == $past(flag_dslot) && btr_we == $past(flag_dslot)));

  assert_fault_status_R7: assert property (@(posedge clk) disable iff (rst)
    (taken && cause == 3'd1) |-> (ear_we && ear_val == $past(flt_addr)
                                  && esr_val[ESR_ST] == ($past(flt_acc) == 2'd2)));

  assert_mode_save_R8: assert property (@(posedge clk) disable iff (rst)
    taken |-> (!msr_out[MSR_UM] && !msr_out[MSR_VM]
               && msr_out[MSR_UM+1] == $past(cur_msr[MSR_UM])
               && msr_out[MSR_VM+1] == $past(cur_msr[MSR_VM])));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !taken |-> (!link_we && !esr_we && !ear_we && !btr_we && !resv_kill && !iflag_clr));

  assert_priority_R11: assert property (@(posedge clk) disable iff (rst)
    (taken && cause != 3'd1) |-> !$past(flt_req));

  assert_exc_gate_R12: assert property (@(posedge clk) disable iff (rst)
    (taken && cause == 3'd2) |-> $past(cfg_exc_en));

endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .MSR_W(MSR_W), .ESR_W(ESR_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_exc_en(cfg_exc_en), .cfg_vec_base(cfg_vec_base),
  .cur_pc(cur_pc), .cur_msr(cur_msr), .flag_dslot(flag_dslot), .flag_imm(flag_imm),
  .flag_bimm(flag_bimm), .irq_pend(irq_pend), .flt_req(flt_req), .flt_acc(flt_acc),
  .flt_addr(flt_addr), .taken(taken), .cause(cause), .new_pc(new_pc),
  .link_we(link_we), .link_idx(link_idx), .link_val(link_val), .msr_out(msr_out),
  .esr_we(esr_we), .esr_val(esr_val), .ear_we(ear_we), .ear_val(ear_val),
  .btr_we(btr_we), .resv_kill(resv_kill), .iflag_clr(iflag_clr)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;

  localparam logic [31:0] PC   = 32'h0000_1000;
  localparam logic [31:0] BASE = 32'h0000_8000;
  localparam logic [31:0] BTGT = 32'h2222_0000;
  localparam logic [31:0] FADR = 32'h3333_0040;
  localparam logic [31:0] UADR = 32'h4444_0003;

  typedef struct packed {
    logic irq, brk, exc, flt, en, ds, imm, bimm, prot;
    logic [1:0]  acc;
    logic [15:0] msr;
    logic        t;
    logic [2:0]  cs;
    logic [4:0]  idx;
    logic [4:0]  delta;
    logic [7:0]  vec;
    logic [15:0] esr;
    logic [15:0] mout;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t TBL [NV] = '{
    {9'b1000_1000_0, 2'd0, 16'h2802, 1'b1, 3'd4, 5'd14, 5'h00, 8'h10, 16'h0000, 16'h5000, 4'd2},
    {9'b1000_1000_0, 2'd0, 16'h2800, 1'b0, 3'd0, 5'd0,  5'h00, 8'h00, 16'h0000, 16'h0000, 4'd1},
    {9'b1000_1000_0, 2'd0, 16'h2A02, 1'b0, 3'd0, 5'd0,  5'h00, 8'h00, 16'h0000, 16'h0000, 4'd1},
    {9'b1000_1000_0, 2'd0, 16'h280A, 1'b0, 3'd0, 5'd0,  5'h00, 8'h00, 16'h0000, 16'h0000, 4'd1},
    {9'b1000_1100_0, 2'd0, 16'h2802, 1'b0, 3'd0, 5'd0,  5'h00, 8'h00, 16'h0000, 16'h0000, 4'd1},
    {9'b1000_1010_0, 2'd0, 16'h2802, 1'b0, 3'd0, 5'd0,  5'h00, 8'h00, 16'h0000, 16'h0000, 4'd1},
    {9'b0100_1000_0, 2'd0, 16'h0802, 1'b1, 3'd3, 5'd16, 5'h00, 8'h18, 16'h0000, 16'h100A, 4'd3},
    {9'b0010_1000_0, 2'd0, 16'h2002, 1'b1, 3'd2, 5'd17, 5'h04, 8'h20, 16'h0007, 16'h4202, 4'd4},
    {9'b0010_1100_0, 2'd0, 16'h2002, 1'b1, 3'd2, 5'd17, 5'h04, 8'h20, 16'h1007, 16'h4202, 4'd6},
    {9'b0010_0000_0, 2'd0, 16'h2002, 1'b0, 3'd0, 5'd0,  5'h00, 8'h00, 16'h0000, 16'h0000, 4'd12},
    {9'b1010_0000_0, 2'd0, 16'h0002, 1'b1, 3'd4, 5'd14, 5'h00, 8'h10, 16'h0000, 16'h0000, 4'd12},
    {9'b0001_1000_0, 2'd1, 16'h0000, 1'b1, 3'd1, 5'd17, 5'h00, 8'h20, 16'h0012, 16'h0200, 4'd7},
    {9'b0001_1000_1, 2'd0, 16'h0000, 1'b1, 3'd1, 5'd17, 5'h00, 8'h20, 16'h0011, 16'h0200, 4'd7},
    {9'b0001_1000_0, 2'd0, 16'h0000, 1'b1, 3'd1, 5'd17, 5'h00, 8'h20, 16'h0013, 16'h0200, 4'd7},
    {9'b0001_1000_1, 2'd2, 16'h0000, 1'b1, 3'd1, 5'd17, 5'h00, 8'h20, 16'h0410, 16'h0200, 4'd7},
    {9'b0001_1101_0, 2'd2, 16'h0000, 1'b1, 3'd1, 5'd17, 5'h18, 8'h20, 16'h1412, 16'h0200, 4'd5},
    {9'b0001_1100_0, 2'd1, 16'h0000, 1'b1, 3'd1, 5'd17, 5'h1C, 8'h20, 16'h1012, 16'h0200, 4'd5},
    {9'b0001_1010_1, 2'd1, 16'h0000, 1'b1, 3'd1, 5'd17, 5'h1C, 8'h20, 16'h0010, 16'h0200, 4'd5},
    {9'b1111_1000_0, 2'd1, 16'h0002, 1'b1, 3'd1, 5'd17, 5'h00, 8'h20, 16'h0012, 16'h0202, 4'd11},
    {9'b1100_1000_0, 2'd0, 16'h0002, 1'b1, 3'd3, 5'd16, 5'h00, 8'h18, 16'h0000, 16'h000A, 4'd11},
    {9'b0110_1000_0, 2'd0, 16'h0000, 1'b1, 3'd2, 5'd17, 5'h04, 8'h20, 16'h0007, 16'h0200, 4'd11},
    {9'b0000_1000_0, 2'd0, 16'h2802, 1'b0, 3'd0, 5'd0,  5'h00, 8'h00, 16'h0000, 16'h0000, 4'd9}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_exc_en = 1'b0;
  logic [31:0] cur_pc = PC, br_target = BTGT, exc_addr = UADR, flt_addr = FADR;
  logic [31:0] cur_msr = '0;
  logic flag_dslot = 0, flag_imm = 0, flag_bimm = 0;
  logic irq_pend = 0, brk_req = 0, exc_req = 0, exc_unaligned = 0, flt_req = 0, flt_prot = 0;
  logic [4:0] exc_code = 5'd7;
  logic [6:0] exc_syndrome = 7'h7F;
  logic [1:0] flt_acc = 2'd0;
  logic taken, link_we, esr_we, ear_we, btr_we, resv_kill, iflag_clr;
  logic [2:0] cause;
  logic [4:0] link_idx;
  logic [31:0] new_pc, link_val, msr_out, esr_val, ear_val, btr_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_exc_en(cfg_exc_en), .cfg_vec_base(BASE),
    .cur_pc(cur_pc), .cur_msr(cur_msr), .flag_dslot(flag_dslot), .flag_imm(flag_imm),
    .flag_bimm(flag_bimm), .br_target(br_target), .irq_pend(irq_pend), .brk_req(brk_req),
    .exc_req(exc_req), .exc_unaligned(exc_unaligned), .exc_code(exc_code),
    .exc_syndrome(exc_syndrome), .exc_addr(exc_addr), .flt_req(flt_req),
    .flt_prot(flt_prot), .flt_acc(flt_acc), .flt_addr(flt_addr),
    .taken(taken), .cause(cause), .new_pc(new_pc), .link_we(link_we),
    .link_idx(link_idx), .link_val(link_val), .msr_out(msr_out), .esr_we(esr_we),
    .esr_val(esr_val), .ear_we(ear_we), .ear_val(ear_val), .btr_we(btr_we),
    .btr_val(btr_val), .resv_kill(resv_kill), .iflag_clr(iflag_clr)
  );

  function automatic string tag(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd9: return "R9";   4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic idle();
    irq_pend = 0; brk_req = 0; exc_req = 0; flt_req = 0; exc_unaligned = 0;
    flag_dslot = 0; flag_imm = 0; flag_bimm = 0; flt_prot = 0; flt_acc = 2'd0;
    exc_syndrome = 7'h7F; cur_msr = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++; errors++;
        $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 20000);
        finish_run();
      end
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9", "taken after reset", {31'b0, taken}, 32'd0);
    chk("R9", "link_we after reset", {31'b0, link_we}, 32'd0);
    chk("R9", "new_pc after reset", new_pc, 32'd0);
    @(negedge clk); rst = 0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string r;
      v = TBL[i];
      r = tag(v.rq);
      @(negedge clk);
      irq_pend = v.irq; brk_req = v.brk; exc_req = v.exc; flt_req = v.flt;
      cfg_exc_en = v.en; flag_dslot = v.ds; flag_imm = v.imm; flag_bimm = v.bimm;
      flt_prot = v.prot; flt_acc = v.acc; cur_msr = {16'h0, v.msr};
      @(posedge clk); #1;
      chk(r, "taken", {31'b0, taken}, {31'b0, v.t});
      if (v.t) begin
        chk(r, "cause", {29'b0, cause}, {29'b0, v.cs});
        chk(r, "link_idx", {27'b0, link_idx}, {27'b0, v.idx});
        chk(r, "link_val", link_val, PC + {{27{v.delta[4]}}, v.delta});
        chk(r, "new_pc", new_pc, BASE + {24'b0, v.vec});
        chk("R8", "msr_out", msr_out, {16'h0, v.mout});
        chk("R9", "clear strobes", {30'b0, resv_kill, iflag_clr}, 32'd3);
        if (v.cs == 3'd1 || v.cs == 3'd2) begin
          chk(r, "esr_val", esr_val, {16'h0, v.esr});
          chk("R6", "btr_we", {31'b0, btr_we}, {31'b0, v.ds});
          if (v.ds) chk("R6", "btr_val", btr_val, BTGT);
        end else begin
          chk(r, "esr_we", {31'b0, esr_we}, 32'd0);
        end
        if (v.cs == 3'd1) chk("R7", "ear_val", ear_val, FADR);
      end else begin
        chk(r, "no writes", {28'b0, link_we, esr_we, ear_we, btr_we}, 32'd0);
      end
    end

    // R10: unaligned data exception, outside and inside a delay slot
    @(negedge clk);
    idle(); cfg_exc_en = 1; exc_req = 1; exc_unaligned = 1; exc_syndrome = 7'h5A;
    @(posedge clk); #1;
    chk("R10", "unaligned esr", esr_val, 32'h0000_0B41);
    chk("R10", "unaligned ear", {31'b0, ear_we} ^ 32'd1 | (ear_val ^ UADR), 32'd0);
    @(negedge clk);
    flag_dslot = 1;
    @(posedge clk); #1;
    chk("R10", "unaligned esr in slot", esr_val, 32'h0000_1B41);
    chk("R6", "btr in slot", btr_val, BTGT);

    // R9: one request cycle gives one pulse, then quiet
    @(negedge clk);
    idle(); brk_req = 1;
    @(posedge clk); #1;
    chk("R9", "pulse high", {29'b0, taken, resv_kill, iflag_clr}, 32'd7);
    @(negedge clk);
    idle();
    @(posedge clk); #1;
    chk("R9", "pulse low", {29'b0, taken, resv_kill, iflag_clr}, 32'd0);

    // R12: gated exception with no other request leaves outputs quiet
    @(negedge clk);
    idle(); cfg_exc_en = 0; exc_req = 1; exc_unaligned = 1;
    @(posedge clk); #1;
    chk("R12", "gated exception", {30'b0, taken, ear_we}, 32'd0);

    @(negedge clk); idle();
    finish_run();
  end

endmodule